// File: doc/BRIEF.md
# Alamouti-Structured 2x2 Complex Matrix Inverter

This block inverts a 2x2 complex matrix whose layout is [a1 a2; -conj(a2) conj(a1)]. A matrix of that shape is fully described by its two upper entries. Its inverse has the same shape, so the block takes only the two describing values a1 and a2 and returns only the two describing values of the inverse, x1 and x2. An expanded pair of outputs also supplies the lower row of the inverse. The lower row is obtained from x1 and x2 by conjugation and sign changes alone.

The arithmetic uses the structure of the matrix. First, one real sum of four squares gives alpha = |a1|^2 + |a2|^2, which takes the place of a complex determinant. Next, an iterative restoring divider forms a fixed-point reciprocal of alpha over a constant number of cycles. Finally, four real-by-real multiplies scale conj(a1) and -a2 by that reciprocal. All values are signed fixed point: entries are 16-bit with 13 fraction bits, and alpha is 34 bits wide. Results saturate. An all-zero input is reported as singular.

The control is a four-state machine. `ST_IDLE` holds in_ready high and leaves on an accepted input (transition *accept*). `ST_SUMSQ` forms alpha and starts the divider (transition *start divide*). `ST_DIVIDE` runs until the divider reports its last quotient bit (transition *quotient complete*). `ST_SCALE` registers the results, raises out_done and always returns to `ST_IDLE` (transition *deliver*).

Top module: `alm_inv_top`

## Requirements
- R1: While reset is held and directly after it: in_ready is 1, out_done is 0, out_singular is 0, and every result output is 0.
- R2: An input is taken on a rising edge where in_valid and in_ready are both 1. From that edge until the result is delivered, in_ready is 0.
- R3: out_done is 1 for exactly one cycle. That cycle begins on the 51st rising edge after the accepting edge (RECIP_SHIFT+3 edges).
- R4: Treating the input words as integers, alpha = a1_re^2 + a1_im^2 + a2_re^2 + a2_im^2. The reciprocal is R = floor(2^48 / alpha).
- R5: With S(v) = saturate(floor(v*R / 2^22)): x1_re = S(a1_re) and x1_im = S(-a1_im).
- R6: x2_re = S(-a2_re) and x2_im = S(-a2_im).
- R7: Every result saturates to the symmetric range -32767..32767. For example, a1 = (1,0) with a2 = 0 gives x1_re = 32767.
- R8: The lower-left output equals (-x2_re, x2_im). The lower-right output equals (x1_re, -x1_im).
- R9: When alpha is 0, out_singular is 1 and all eight result outputs are 0 in the delivery cycle. Otherwise out_singular is 0.
- R10: Results and out_singular keep their values between deliveries. Changes on the inputs and on in_valid while in_ready is 0 have no effect on any result.
- R11: in_ready is 1 in the same cycle that out_done is 1, so a new input can be taken on the edge that ends a delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pair offered |
| in_ready | output | 1 | Block can take an input |
| a1_re | input | 16 | Real part of a1, Q2.13 |
| a1_im | input | 16 | Imaginary part of a1, Q2.13 |
| a2_re | input | 16 | Real part of a2, Q2.13 |
| a2_im | input | 16 | Imaginary part of a2, Q2.13 |
| out_done | output | 1 | One-cycle result strobe |
| out_singular | output | 1 | alpha was zero |
| x1_re | output | 16 | Real part of x1 |
| x1_im | output | 16 | Imaginary part of x1 |
| x2_re | output | 16 | Real part of x2 |
| x2_im | output | 16 | Imaginary part of x2 |
| y_bl_re | output | 16 | Lower-left entry, real part |
| y_bl_im | output | 16 | Lower-left entry, imaginary part |
| y_br_re | output | 16 | Lower-right entry, real part |
| y_br_im | output | 16 | Lower-right entry, imaginary part |

## Verification
Two things can happen in the same cycle: delivery of one result in `ST_SCALE`→`ST_IDLE` and acceptance of the next input. The bench provokes this by holding in_valid high across whole runs, so a fresh pair is taken on the edge right after out_done. The bench also drives changing inputs with in_valid high while the block is busy. A cycle-accurate behavioural model predicts in_ready, out_done and every output on every clock. The comparison shows whether the overlapping cycle both keeps the delivered values and starts the new operation on the correct operands.

// File: rtl/alm_inv_pkg.sv
`timescale 1ns/1ps
package alm_inv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SUMSQ,
        ST_DIVIDE,
        ST_SCALE
    } alm_state_e;
endpackage

// File: rtl/alm_sumsq.sv
`timescale 1ns/1ps
// Real sum of the squares of four signed components.
module alm_sumsq #(
    parameter int DW = 16,
    parameter int AW = 2*DW+2
) (
    input  logic [4*DW-1:0] comps,
    output logic [AW-1:0]   alpha
);
    logic signed [2*DW-1:0] sq [4];

    for (genvar i = 0; i < 4; i++) begin : g_sq
        logic signed [DW-1:0] c;
        assign c     = comps[i*DW +: DW];
        assign sq[i] = c * c;
    end

    always_comb begin
        alpha = '0;
        for (int i = 0; i < 4; i++) begin
            alpha = alpha + AW'($unsigned(sq[i]));
        end
    end
endmodule

// File: rtl/alm_recip_div.sv
`timescale 1ns/1ps
// Restoring divider: quotient = floor(2^(QW-1) / divisor), one bit per cycle.
module alm_recip_div #(
    parameter int AW = 34,
    parameter int QW = 49
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] divisor,
    output logic          last,
    output logic [QW-1:0] quotient
);
    localparam int CW = $clog2(QW+1);

    logic [AW-1:0] rem_q, dvsr_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic [AW:0]   trial;
    logic          fits;

    assign last  = busy_q && (cnt_q == CW'(QW-1));
    assign trial = {rem_q, (cnt_q == '0)};
    assign fits  = trial >= {1'b0, dvsr_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q    <= '0;
            dvsr_q   <= '0;
            cnt_q    <= '0;
            busy_q   <= 1'b0;
            quotient <= '0;
        end else if (start) begin
            rem_q    <= '0;
            dvsr_q   <= divisor;
            cnt_q    <= '0;
            busy_q   <= 1'b1;
            quotient <= '0;
        end else if (busy_q) begin
            rem_q    <= fits ? AW'(trial - {1'b0, dvsr_q}) : AW'(trial);
            quotient <= {quotient[QW-2:0], fits};
            cnt_q    <= cnt_q + 1'b1;
            if (last) busy_q <= 1'b0;
        end
    end

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && dvsr_q != '0) |-> (rem_q < dvsr_q)); // R4
    AST_LAST_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !busy_q); // R3
endmodule

// File: rtl/alm_scale.sv
`timescale 1ns/1ps
// y = saturate(floor(+/-v * recip / 2^SHIFT)), symmetric range.
module alm_scale #(
    parameter int DW    = 16,
    parameter int QW    = 49,
    parameter int SHIFT = 22
) (
    input  logic signed [DW-1:0] v,
    input  logic                 negate,
    input  logic [QW-1:0]        recip,
    output logic signed [DW-1:0] y
);
    localparam int PW   = DW + QW + 2;
    localparam int MAXV = 2**(DW-1) - 1;

    logic signed [DW:0]   vx;
    logic signed [PW-1:0] vw, rw, prod, sh;

    assign vx   = negate ? -(DW+1)'(v) : (DW+1)'(v);
    assign vw   = PW'(vx);
    assign rw   = $signed(PW'(recip));
    assign prod = vw * rw;
    assign sh   = prod >>> SHIFT;

    always_comb begin
        if (sh > $signed(PW'(MAXV)))       y = DW'(MAXV);
        else if (sh < -$signed(PW'(MAXV))) y = -DW'(MAXV);
        else                               y = sh[DW-1:0];
    end
endmodule

// File: rtl/alm_inv_top.sv
`timescale 1ns/1ps
module alm_inv_top #(
    parameter int DW          = 16,
    parameter int FRAC        = 13,
    parameter int RECIP_SHIFT = 48,
    parameter bit EXPAND      = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [DW-1:0] a1_re,
    input  logic signed [DW-1:0] a1_im,
    input  logic signed [DW-1:0] a2_re,
    input  logic signed [DW-1:0] a2_im,
    output logic                 out_done,
    output logic                 out_singular,
    output logic signed [DW-1:0] x1_re,
    output logic signed [DW-1:0] x1_im,
    output logic signed [DW-1:0] x2_re,
    output logic signed [DW-1:0] x2_im,
    output logic signed [DW-1:0] y_bl_re,
    output logic signed [DW-1:0] y_bl_im,
    output logic signed [DW-1:0] y_br_re,
    output logic signed [DW-1:0] y_br_im
);
    import alm_inv_pkg::*;

    localparam int AW    = 2*DW + 2;
    localparam int QW    = RECIP_SHIFT + 1;
    localparam int SHIFT = RECIP_SHIFT - 2*FRAC;
    localparam int MAXV  = 2**(DW-1) - 1;

    alm_state_e      state_q, state_d;
    logic [4*DW-1:0] cap_q;
    logic [4*DW-1:0] res_q;
    logic [4*DW-1:0] scaled;
    logic [AW-1:0]   alpha;
    logic [QW-1:0]   recip;
    logic            zero_q;
    logic            div_last;
    logic            accept;

    assign in_ready = (state_q == ST_IDLE);
    assign accept   = in_valid && in_ready;

    alm_sumsq #(.DW(DW), .AW(AW)) u_sumsq (
        .comps (cap_q),
        .alpha (alpha)
    );

    alm_recip_div #(.AW(AW), .QW(QW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (state_q == ST_SUMSQ),
        .divisor  (alpha),
        .last     (div_last),
        .quotient (recip)
    );

    // slice 3: a1_re (kept), slice 2: a1_im, 1: a2_re, 0: a2_im (negated)
    for (genvar i = 0; i < 4; i++) begin : g_scale
        alm_scale #(.DW(DW), .QW(QW), .SHIFT(SHIFT)) u_scale (
            .v      (cap_q[i*DW +: DW]),
            .negate (i != 3),
            .recip  (recip),
            .y      (scaled[i*DW +: DW])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)   state_d = ST_SUMSQ;
            ST_SUMSQ:                state_d = ST_DIVIDE;
            ST_DIVIDE: if (div_last) state_d = ST_SCALE;
            ST_SCALE:                state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q        <= '0;
            res_q        <= '0;
            zero_q       <= 1'b0;
            out_done     <= 1'b0;
            out_singular <= 1'b0;
        end else begin
            out_done <= 1'b0;
            unique case (state_q)
                ST_IDLE:   if (accept) cap_q <= {a1_re, a1_im, a2_re, a2_im};
                ST_SUMSQ:  zero_q <= (alpha == '0);
                ST_DIVIDE: ;
                ST_SCALE: begin
                    res_q        <= zero_q ? '0 : scaled;
                    out_singular <= zero_q;
                    out_done     <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign x1_re = res_q[3*DW +: DW];
    assign x1_im = res_q[2*DW +: DW];
    assign x2_re = res_q[1*DW +: DW];
    assign x2_im = res_q[0 +: DW];

    if (EXPAND) begin : g_expand
        assign y_bl_re = -x2_re;
        assign y_bl_im =  x2_im;
        assign y_br_re =  x1_re;
        assign y_br_im = -x1_im;
    end else begin : g_compact
        assign y_bl_re = '0;
        assign y_bl_im = '0;
        assign y_br_re = '0;
        assign y_br_im = '0;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_done); // R3
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !in_ready); // R2
    AST_READY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> in_ready); // R11
    AST_SAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> (x1_re >= -MAXV && x1_im >= -MAXV && x2_re >= -MAXV && x2_im >= -MAXV)); // R7
    AST_SINGULAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && out_singular) |-> (x1_re == 0 && x1_im == 0 && x2_re == 0 && x2_im == 0)); // R9
    AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
        !out_done |-> ($stable(x1_re) && $stable(x1_im) && $stable(x2_re) && $stable(x2_im)
                       && $stable(out_singular))); // R10
endmodule

// File: tb/test_alm_inv_top.sv
`timescale 1ns/1ps
module test_alm_inv_top;
    localparam int LAT = 51;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [15:0] a1_re = '0, a1_im = '0, a2_re = '0, a2_im = '0;
    logic in_ready, out_done, out_singular;
    logic signed [15:0] x1_re, x1_im, x2_re, x2_im;
    logic signed [15:0] y_bl_re, y_bl_im, y_br_re, y_br_im;

    int errors = 0;
    int checks = 0;

    // model state
    bit m_ready = 1'b1;
    bit m_done  = 1'b0;
    int m_cnt   = 0;
    int m_out [9];
    int m_pend [9];
    int unsigned seed = 32'h1234_5678;

    always #10 clk = ~clk;

    alm_inv_top i_alm_inv_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .a1_re(a1_re), .a1_im(a1_im), .a2_re(a2_re), .a2_im(a2_im),
        .out_done(out_done), .out_singular(out_singular),
        .x1_re(x1_re), .x1_im(x1_im), .x2_re(x2_re), .x2_im(x2_im),
        .y_bl_re(y_bl_re), .y_bl_im(y_bl_im), .y_br_re(y_br_re), .y_br_im(y_br_im)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sc(int v, longint rec);
        logic signed [95:0] p;
        p = v;
        p = p * rec;
        p = p >>> 22;
        if (p > 32767) return 32767;
        if (p < -32767) return -32767;
        return int'(p);
    endfunction

    // R4, R5, R6, R8, R9: behavioural reference
    task automatic predict(int p, int q, int r, int s);
        longint alpha, rec;
        alpha = longint'(p)*p + longint'(q)*q + longint'(r)*r + longint'(s)*s;
        if (alpha == 0) begin
            foreach (m_pend[k]) m_pend[k] = 0;
            m_pend[8] = 1;
        end else begin
            rec = (longint'(1) <<< 48) / alpha;
            m_pend[0] = sc(p, rec);
            m_pend[1] = sc(-q, rec);
            m_pend[2] = sc(-r, rec);
            m_pend[3] = sc(-s, rec);
            m_pend[4] = -m_pend[2];
            m_pend[5] =  m_pend[3];
            m_pend[6] =  m_pend[0];
            m_pend[7] = -m_pend[1];
            m_pend[8] = 0;
        end
    endtask

    task automatic compare();
        string rq;
        chk("R2 in_ready", int'(in_ready), int'(m_ready));
        chk("R3 out_done", int'(out_done), int'(m_done));
        if (m_done) chk("R11 ready with done", int'(in_ready), 1);
        rq = m_done ? "R5" : "R10";
        chk({rq, " x1_re"}, int'(x1_re), m_out[0]);
        chk({rq, " x1_im"}, int'(x1_im), m_out[1]);
        rq = m_done ? "R6" : "R10";
        chk({rq, " x2_re"}, int'(x2_re), m_out[2]);
        chk({rq, " x2_im"}, int'(x2_im), m_out[3]);
        rq = m_done ? "R8" : "R10";
        chk({rq, " y_bl_re"}, int'(y_bl_re), m_out[4]);
        chk({rq, " y_bl_im"}, int'(y_bl_im), m_out[5]);
        chk({rq, " y_br_re"}, int'(y_br_re), m_out[6]);
        chk({rq, " y_br_im"}, int'(y_br_im), m_out[7]);
        rq = m_done ? "R9" : "R10";
        chk({rq, " singular"}, int'(out_singular), m_out[8]);
    endtask

    task automatic step(bit v, int p, int q, int r, int s);
        bit prev_ready;
        @(negedge clk);
        compare();
        in_valid = v;
        a1_re = 16'(p); a1_im = 16'(q); a2_re = 16'(r); a2_im = 16'(s);
        @(posedge clk);
        prev_ready = m_ready;
        m_done = 1'b0;
        if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_done = 1'b1;
                m_ready = 1'b1;
                m_out = m_pend;
            end
        end
        if (v && prev_ready) begin
            m_ready = 1'b0;
            m_cnt = LAT;
            predict(p, q, r, s);
        end
    endtask

    function automatic int rnd16();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'($signed(seed[30:15]));
    endfunction

    // one operation; garbage with in_valid high while busy (R10)
    task automatic run(int p, int q, int r, int s);
        step(1'b1, p, q, r, s);
        for (int k = 0; k < LAT + 1; k++) begin
            if (k < LAT - 4) step(1'b1, rnd16(), rnd16(), rnd16(), rnd16());
            else             step(1'b0, rnd16(), rnd16(), rnd16(), rnd16());
        end
    endtask

    initial begin
        foreach (m_out[k]) m_out[k] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 in_ready", int'(in_ready), 1);
        chk("R1 out_done", int'(out_done), 0);
        chk("R1 singular", int'(out_singular), 0);
        chk("R1 x1_re", int'(x1_re), 0);
        chk("R1 y_br_im", int'(y_br_im), 0);
        rst_n = 1'b1;

        run(8192, 0, 0, 0);                 // identity
        chk("R4 identity x1_re", int'(x1_re), 8192);
        chk("R4 identity x2_re", int'(x2_re), 0);
        run(0, 0, 0, 0);                    // singular
        chk("R9 singular flag", int'(out_singular), 1);
        run(1, 0, 0, 0);                    // positive saturation
        chk("R7 sat high", int'(x1_re), 32767);
        run(0, 0, 2, 0);                    // negative saturation
        chk("R7 sat low", int'(x2_re), -32767);
        run(-32768, -32768, -32768, -32768);// extreme magnitude
        chk("R6 extreme x2_re", int'(x2_re), 512);
        run(4096, 4096, -8192, 16384);
        for (int n = 0; n < 6; n++) run(rnd16(), rnd16(), rnd16(), rnd16());
        // R11: back-to-back with valid held high across deliveries
        for (int n = 0; n < 3 * (LAT + 2); n++) begin
            if (n < LAT + 2) step(1'b1, 3000, -2000, 1000, 500);
            else             step(1'b1, -7000, 100, 2500, -4000);
        end
        for (int k = 0; k < LAT + 3; k++) step(1'b0, 0, 0, 0, 0);
        @(negedge clk);
        compare();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R3 watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule